// File: doc/BRIEF.md
# I2C Address Buffer Controller

This block sits beside the transmit shift register of an I2C controller. It decides which byte the shift register receives during the address phase of a transfer. It keeps two address buffer registers and one software-written transmit data buffer. The source byte is chosen from a 3-bit operating mode field and a buffer bypass bit. When the buffers are in use, it issues one single-cycle load strobe with an 8-bit data byte for every address byte.

In 10-bit master operation, the block sends the upper address byte first and then waits for the slave's acknowledge. The lower address byte is sent only when that acknowledge is positive; a negative acknowledge ends the sequence with a one-cycle status pulse. In multi-master operation, a slave address that matched on the bus is copied into buffer 0. The master side of multi-master operation takes its address from buffer 1. Bit timing, arbitration and the data phase belong to other blocks.

Top module: `i2c_adrbuf_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `adb0_q`, `adb1_q`, `txb_q` and `load_data` read 8'h00, and `load_stb`, `nack_pulse` and `busy` are low.
- R2: A write with `wr_en` high stores `wr_data` one cycle later: `wr_sel` 0 selects buffer 0, 1 selects buffer 1 and 2 selects the transmit data buffer. `wr_sel` 3 changes no register.
- R3: In 7-bit master mode (`mode` 3'b100) with `buf_dis` low, a `start_req` sampled while not busy makes `load_stb` high for exactly one cycle in the next cycle, with `load_data` equal to buffer 1. `busy` stays low.
- R4: In multi-master mode (`mode` 3'b111) with `buf_dis` low, a `start_req` gives one load of buffer 1 in the next cycle. `busy` stays low.
- R5: With `buf_dis` high, a `start_req` in any master mode (3'b100, 3'b101 or 3'b111) gives one load of the transmit data buffer in the next cycle. No second load follows and `busy` stays low, even in 10-bit mode.
- R6: In 10-bit master mode (`mode` 3'b101) with `buf_dis` low, `start_req` loads buffer 1 in the next cycle and raises `busy`. A later `ack_valid` with `ack_nack` low loads buffer 0 in the following cycle and clears `busy`.
- R7: While `busy` is high, an `ack_valid` with `ack_nack` high gives a one-cycle `nack_pulse` in the next cycle, with no load, and clears `busy`.
- R8: In any mode other than 3'b100, 3'b101 and 3'b111, `start_req` produces no load.
- R9: In multi-master mode, `match_valid` writes `match_addr` into buffer 0 one cycle later, and it wins over a software write to buffer 0 in the same cycle. In every other mode, `match_valid` is ignored.
- R10: `start_req` while `busy` is high, and `ack_valid` while `busy` is low, produce no load and no `nack_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Operating mode field |
| buf_dis | input | 1 | 1 = address buffers bypassed, the transmit data buffer supplies the address |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 buffer 0, 1 buffer 1, 2 transmit data buffer, 3 none |
| wr_data | input | 8 | Write data |
| start_req | input | 1 | Address phase request |
| ack_valid | input | 1 | Acknowledge bit received for the first 10-bit address byte |
| ack_nack | input | 1 | 1 = negative acknowledge |
| match_valid | input | 1 | Received slave address matched |
| match_addr | input | 8 | Received matching address byte |
| load_stb | output | 1 | Shift register load strobe |
| load_data | output | 8 | Byte to load into the shift register |
| nack_pulse | output | 1 | One-cycle pulse on a negative acknowledge |
| busy | output | 1 | Waiting for the acknowledge of the first 10-bit byte |
| adb0_q | output | 8 | Buffer 0 contents |
| adb1_q | output | 8 | Buffer 1 contents |
| txb_q | output | 8 | Transmit data buffer contents |

## Verification
Every result is registered once. A write, a match capture, a load strobe, a NACK pulse and a change of `busy` therefore appear exactly one clock after the edge that sampled the causing input. For a 10-bit address, the second byte comes one clock after the acknowledge edge, however long the wait was. The bench drives inputs 1 ns after a rising edge and computes the expected outputs from its model and those inputs. It then compares every output 1 ns after the next rising edge, so each comparison falls within the single-cycle latency window.

// File: rtl/i2c_adrbuf_pkg.sv
package i2c_adrbuf_pkg;
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_M7  = 3'b100;
   localparam logic [MODE_W-1:0] MODE_M10 = 3'b101;
   localparam logic [MODE_W-1:0] MODE_MM7 = 3'b111;

   localparam int SEL_ADB0 = 0;
   localparam int SEL_ADB1 = 1;
   localparam int SEL_TXB  = 2;

   typedef enum logic {
      SQ_IDLE     = 1'b0,
      SQ_WAIT_ACK = 1'b1
   } sq_state_t;

   function automatic logic is_master(input logic [MODE_W-1:0] m);
      return (m == MODE_M7) || (m == MODE_M10) || (m == MODE_MM7);
   endfunction
endpackage

// File: rtl/i2c_adrbuf_regs.sv
module i2c_adrbuf_regs #(
   parameter int DATA_W  = 8,
   parameter int NUM_REG = 3,
   parameter int SEL_W   = 2,
   parameter int CAP_IDX = 0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [SEL_W-1:0]                wr_sel,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            cap_en,
   input  logic [DATA_W-1:0]               cap_data,
   output logic [NUM_REG-1:0][DATA_W-1:0]  q
);
   generate
      if ((2 ** SEL_W) < NUM_REG) begin : g_bad_sel
         $error("SEL_W too narrow for NUM_REG");
      end
      if (CAP_IDX >= NUM_REG) begin : g_bad_cap
         $error("CAP_IDX out of range");
      end
   endgenerate

   logic [DATA_W-1:0] r [NUM_REG];

   generate
      for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
         logic hit;
         assign hit  = wr_en && (wr_sel == SEL_W'(g));
         assign q[g] = r[g];
         if (g == CAP_IDX) begin : g_cap
            always_ff @(posedge clk) begin
               if (!rst_n)      r[g] <= '0;
               else if (cap_en) r[g] <= cap_data;
               else if (hit)    r[g] <= wr_data;
            end
         end else begin : g_plain
            always_ff @(posedge clk) begin
               if (!rst_n)   r[g] <= '0;
               else if (hit) r[g] <= wr_data;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_adrbuf_pick.sv
module i2c_adrbuf_pick
   import i2c_adrbuf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [MODE_W-1:0] mode,
   input  logic              buf_dis,
   input  logic [DATA_W-1:0] adb1,
   input  logic [DATA_W-1:0] txb,
   output logic              master,
   output logic              two_byte,
   output logic [DATA_W-1:0] first_byte
);
   always_comb begin
      master     = is_master(mode);
      two_byte   = master && (mode == MODE_M10) && !buf_dis;
      first_byte = buf_dis ? txb : adb1;
   end
endmodule

// File: rtl/i2c_adrbuf_seq.sv
module i2c_adrbuf_seq
   import i2c_adrbuf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              master,
   input  logic              two_byte,
   input  logic [DATA_W-1:0] first_byte,
   input  logic [DATA_W-1:0] second_byte,
   input  logic              ack_valid,
   input  logic              ack_nack,
   output logic              load_stb,
   output logic [DATA_W-1:0] load_data,
   output logic              nack_pulse,
   output logic              busy
);
   sq_state_t state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         load_stb   <= 1'b0;
         load_data  <= '0;
         nack_pulse <= 1'b0;
      end else begin
         load_stb   <= 1'b0;
         nack_pulse <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (start_req && master) begin
                  load_stb  <= 1'b1;
                  load_data <= first_byte;
                  if (two_byte) state <= SQ_WAIT_ACK;
               end
            end
            SQ_WAIT_ACK: begin
               if (ack_valid) begin
                  state <= SQ_IDLE;
                  if (!ack_nack) begin
                     load_stb  <= 1'b1;
                     load_data <= second_byte;
                  end else begin
                     nack_pulse <= 1'b1;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy = (state == SQ_WAIT_ACK);
endmodule

// File: rtl/i2c_adrbuf_ctrl.sv
module i2c_adrbuf_ctrl
   import i2c_adrbuf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              buf_dis,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              start_req,
   input  logic              ack_valid,
   input  logic              ack_nack,
   input  logic              match_valid,
   input  logic [DATA_W-1:0] match_addr,
   output logic              load_stb,
   output logic [DATA_W-1:0] load_data,
   output logic              nack_pulse,
   output logic              busy,
   output logic [DATA_W-1:0] adb0_q,
   output logic [DATA_W-1:0] adb1_q,
   output logic [DATA_W-1:0] txb_q
);
   localparam int NUM_REG = 3;
   localparam int SEL_W   = 2;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must hold an address byte");
      end
   endgenerate

   logic [NUM_REG-1:0][DATA_W-1:0] regs_q;
   logic cap_en, master, two_byte;
   logic [DATA_W-1:0] first_byte;

   assign cap_en = match_valid && (mode == MODE_MM7);

   i2c_adrbuf_regs #(
      .DATA_W(DATA_W), .NUM_REG(NUM_REG), .SEL_W(SEL_W), .CAP_IDX(SEL_ADB0)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .cap_en(cap_en), .cap_data(match_addr), .q(regs_q)
   );

   i2c_adrbuf_pick #(.DATA_W(DATA_W)) u_pick (
      .mode(mode), .buf_dis(buf_dis), .adb1(regs_q[SEL_ADB1]),
      .txb(regs_q[SEL_TXB]), .master(master), .two_byte(two_byte),
      .first_byte(first_byte)
   );

   i2c_adrbuf_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .master(master),
      .two_byte(two_byte), .first_byte(first_byte),
      .second_byte(regs_q[SEL_ADB0]), .ack_valid(ack_valid),
      .ack_nack(ack_nack), .load_stb(load_stb), .load_data(load_data),
      .nack_pulse(nack_pulse), .busy(busy)
   );

   assign adb0_q = regs_q[SEL_ADB0];
   assign adb1_q = regs_q[SEL_ADB1];
   assign txb_q  = regs_q[SEL_TXB];
endmodule

// File: rtl/i2c_adrbuf_chk.sv
module i2c_adrbuf_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode,
   input logic              buf_dis,
   input logic              start_req,
   input logic              ack_valid,
   input logic              ack_nack,
   input logic              match_valid,
   input logic [DATA_W-1:0] match_addr,
   input logic              load_stb,
   input logic [DATA_W-1:0] load_data,
   input logic              nack_pulse,
   input logic              busy,
   input logic [DATA_W-1:0] adb0_q,
   input logic [DATA_W-1:0] adb1_q,
   input logic [DATA_W-1:0] txb_q
);
   logic mst;
   assign mst = (mode == 3'b100) || (mode == 3'b101) || (mode == 3'b111);

   assert_m7_adb1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy && mode == 3'b100 && !buf_dis)
      |=> (load_stb && load_data == $past(adb1_q) && !busy));

   assert_mm_adb1_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy && mode == 3'b111 && !buf_dis)
      |=> (load_stb && load_data == $past(adb1_q) && !busy));

   assert_bypass_txb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy && mst && buf_dis)
      |=> (load_stb && load_data == $past(txb_q) && !busy));

   assert_ack_adb0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ack_valid && !ack_nack)
      |=> (load_stb && load_data == $past(adb0_q) && !busy));

   assert_nack_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ack_valid && ack_nack) |=> (nack_pulse && !load_stb && !busy));

   assert_nonmaster_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !mst) |=> !load_stb);

   assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (match_valid && mode == 3'b111) |=> (adb0_q == $past(match_addr)));

   assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_req && ack_valid) |=> (!load_stb && !nack_pulse));

   assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(nack_pulse && load_stb));
endmodule

bind i2c_adrbuf_ctrl i2c_adrbuf_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .buf_dis(buf_dis),
   .start_req(start_req), .ack_valid(ack_valid), .ack_nack(ack_nack),
   .match_valid(match_valid), .match_addr(match_addr), .load_stb(load_stb),
   .load_data(load_data), .nack_pulse(nack_pulse), .busy(busy),
   .adb0_q(adb0_q), .adb1_q(adb1_q), .txb_q(txb_q)
);

// File: tb/i2c_adrbuf_ctrl_tb.sv
module i2c_adrbuf_ctrl_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, buf_dis, wr_en, start_req, ack_valid, ack_nack, match_valid;
   logic [2:0] mode;
   logic [1:0] wr_sel;
   logic [7:0] wr_data, match_addr;
   logic       load_stb, nack_pulse, busy;
   logic [7:0] load_data, adb0_q, adb1_q, txb_q;

   i2c_adrbuf_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .buf_dis(buf_dis), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .start_req(start_req),
      .ack_valid(ack_valid), .ack_nack(ack_nack), .match_valid(match_valid),
      .match_addr(match_addr), .load_stb(load_stb), .load_data(load_data),
      .nack_pulse(nack_pulse), .busy(busy), .adb0_q(adb0_q),
      .adb1_q(adb1_q), .txb_q(txb_q)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic       m_stb, m_nack, m_busy;
   logic [7:0] m_data, m_adb0, m_adb1, m_txb;

   function automatic bit mst(input logic [2:0] m);
      return (m == 3'b100) || (m == 3'b101) || (m == 3'b111);
   endfunction

   task automatic model_step();
      logic       n_stb = 1'b0, n_nack = 1'b0, n_busy = m_busy;
      logic [7:0] n_data = m_data, n0 = m_adb0, n1 = m_adb1, nt = m_txb;
      if (!rst_n) begin
         n_busy = 0; n_data = 0; n0 = 0; n1 = 0; nt = 0;
      end else begin
         if (!m_busy) begin
            if (start_req && mst(mode)) begin
               n_stb  = 1'b1;
               n_data = buf_dis ? m_txb : m_adb1;
               n_busy = (mode == 3'b101) && !buf_dis;
            end
         end else if (ack_valid) begin
            n_busy = 1'b0;
            if (!ack_nack) begin n_stb = 1'b1; n_data = m_adb0; end
            else n_nack = 1'b1;
         end
         if (wr_en) begin
            if (wr_sel == 2'd0) n0 = wr_data;
            if (wr_sel == 2'd1) n1 = wr_data;
            if (wr_sel == 2'd2) nt = wr_data;
         end
         if (match_valid && mode == 3'b111) n0 = match_addr;
      end
      m_stb = n_stb; m_nack = n_nack; m_busy = n_busy; m_data = n_data;
      m_adb0 = n0; m_adb1 = n1; m_txb = nt;
   endtask

   task automatic compare(input string tag);
      checks++;
      if (load_stb !== m_stb || load_data !== m_data || nack_pulse !== m_nack ||
          busy !== m_busy || adb0_q !== m_adb0 || adb1_q !== m_adb1 || txb_q !== m_txb) begin
         fails++;
         $display("FAIL %s: actual stb=%0b data=%h nack=%0b busy=%0b adb0=%h adb1=%h txb=%h expected stb=%0b data=%h nack=%0b busy=%0b adb0=%h adb1=%h txb=%h",
                  tag, load_stb, load_data, nack_pulse, busy, adb0_q, adb1_q, txb_q,
                  m_stb, m_data, m_nack, m_busy, m_adb0, m_adb1, m_txb);
      end
   endtask

   task automatic cyc(input string tag);
      model_step();
      @(posedge clk);
      #1;
      compare(tag);
      wr_en = 0; start_req = 0; ack_valid = 0; ack_nack = 0; match_valid = 0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d, input string tag);
      wr_en = 1; wr_sel = s; wr_data = d;
      cyc(tag);
   endtask

   task automatic go(input logic [2:0] m, input logic dis, input string tag);
      mode = m; buf_dis = dis; start_req = 1;
      cyc(tag);
   endtask

   initial begin
      rst_n = 0; mode = 3'b000; buf_dis = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
      start_req = 0; ack_valid = 0; ack_nack = 0; match_valid = 0; match_addr = 0;
      m_stb = 0; m_nack = 0; m_busy = 0; m_data = 0; m_adb0 = 0; m_adb1 = 0; m_txb = 0;
      wr_en = 1; wr_sel = 2'd1; wr_data = 8'hFF; start_req = 1; mode = 3'b100;
      cyc("R1 in reset");
      cyc("R1 in reset");
      rst_n = 1;
      cyc("R1 after release");

      wr(2'd1, 8'hA5, "R2 buffer1");
      wr(2'd0, 8'h3C, "R2 buffer0");
      wr(2'd2, 8'hC3, "R2 txb");
      wr(2'd3, 8'h77, "R2 sel3 ignored");

      go(3'b100, 0, "R3 7-bit load");
      cyc("R3 strobe single cycle");
      go(3'b111, 0, "R4 multi-master load");
      go(3'b101, 1, "R5 bypass 10-bit");
      cyc("R5 no second load");
      go(3'b100, 1, "R5 bypass 7-bit");

      go(3'b101, 0, "R6 first byte");
      cyc("R6 waiting");
      start_req = 1; cyc("R10 start while busy");
      ack_valid = 1; ack_nack = 0; cyc("R6 second byte after ack");
      cyc("R6 idle after");

      go(3'b101, 0, "R7 first byte");
      ack_valid = 1; ack_nack = 1; cyc("R7 nack pulse");
      cyc("R7 pulse ends");

      go(3'b000, 0, "R8 mode 000");
      go(3'b110, 0, "R8 mode 110");
      go(3'b011, 1, "R8 mode 011");

      ack_valid = 1; cyc("R10 ack while idle");
      ack_valid = 1; ack_nack = 1; cyc("R10 nack while idle");

      mode = 3'b111; match_valid = 1; match_addr = 8'h5A;
      wr_en = 1; wr_sel = 2'd0; wr_data = 8'h11; cyc("R9 capture wins");
      mode = 3'b100; match_valid = 1; match_addr = 8'h99; cyc("R9 ignored in 7-bit");
      mode = 3'b101; match_valid = 1; match_addr = 8'h98; cyc("R9 ignored in 10-bit");

      for (int i = 0; i < 4000; i++) begin
         logic [2:0] mp [6] = '{3'b100, 3'b101, 3'b111, 3'b000, 3'b110, 3'b101};
         mode        = mp[$urandom_range(0, 5)];
         buf_dis     = ($urandom_range(0, 3) == 0);
         wr_en       = $urandom_range(0, 1);
         wr_sel      = 2'($urandom_range(0, 3));
         wr_data     = 8'($urandom);
         start_req   = ($urandom_range(0, 2) == 0);
         ack_valid   = ($urandom_range(0, 2) == 0);
         ack_nack    = $urandom_range(0, 1);
         match_valid = ($urandom_range(0, 3) == 0);
         match_addr  = 8'($urandom);
         if (i == 2000) rst_n = 0;
         if (i == 2003) rst_n = 1;
         cyc("R2/R3/R4/R5/R6/R7/R8/R9/R10 random");
      end

      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd1234);
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule